// File: doc/BRIEF.md
# Single-Bus Processor Core with Step-Counter Control

This block is a minimal processor core in which every register transfer travels over one shared internal bus. Program counter, instruction register, memory address and data registers, a sixteen-entry general register file and two scratch registers (Y and Z) all hang off that bus. The ALU adds the bus to its A operand, which a mux takes either from Y or from the constant 4.

A hardwired controller sequences each instruction as numbered control steps 1 to 7. Steps 1 to 3 fetch the instruction and advance the program counter. From step 4 the opcode picks the remaining transfers. The core reads a word memory over a request/completion handshake. A control step that must wait for memory holds the step counter still until the memory reports completion.

The instruction set has four behaviours: add a memory word to a register, a PC-relative branch, a branch taken only when the negative flag is set, and a no-operation for every other opcode.

Top module: `sbus_core`

## Requirements
- R1: While reset is low, and until the first clock edge after its release, the core is in step 1 with PC 0, the negative flag 0 and every general register 0. `mem_rd` is low in that first cycle, and the first read the core issues is to byte address 0.
- R2: Every instruction starts with a read at the current PC. The next instruction is fetched at PC+4 unless a taken branch redirects it. `mem_addr` equals the PC that was gated to it in step 1.
- R3: `mem_rd` stays high from the cycle after a request until the cycle in which `mem_done` is high, and `mem_addr` holds steady during that time. While a wait step is pending the step counter does not advance. With a memory that answers after L extra cycles, consecutive no-operation fetches start L+4 cycles apart.
- R4: Opcode 1 (bits 31:28) adds from memory: a read is issued at the value of register Rs (bits 23:20), and register Rd (bits 27:24) becomes Rd plus the word read.
- R5: An add whose Rd and Rs name the same register uses that register's old value both as the address and as the addend.
- R6: Opcode 2 is an unconditional branch. The next fetch is at (branch address + 4) plus the sign-extended 16-bit offset in bits 15:0; negative offsets go backwards and wrap modulo 2^32.
- R7: Opcode 3 branches like opcode 2 when the negative flag is 1. When the flag is 0 the next fetch is at the branch address + 4.
- R8: The negative flag takes bit 31 of each add-from-memory result. PC increments and branch-target sums leave it unchanged.
- R9: Opcodes 0 and 4 to 15 change no register and redirect nothing; the next fetch is at PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Byte address of the pending read |
| mem_rd | output | 1 | Read pending, held until completion |
| mem_rdata | input | 32 | Read data, valid with `mem_done` |
| mem_done | input | 1 | Memory completion for the pending read |

## Verification
The bench builds the core with its default 32-bit word and sixteen registers. Its memory model decodes only a 256-word window, so any register value or branch target maps onto a word the bench has filled. That window lets whole programs of pseudo-random words run through an architectural model in the bench, which predicts every read address. These programs are run at memory latencies of 0 to 4 extra cycles, so branches that wrap, self-referencing adds, negative sums and stalls all show up at the address port.

// File: rtl/sbus_core.sv
module sbus_core #(
  parameter int W    = 32,
  parameter int NREG = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_done
);
  localparam int RW     = $clog2(NREG);
  localparam int OFFW   = 16;
  localparam int RD_HI  = W - 5;
  localparam int RS_HI  = RD_HI - RW;
  localparam int GAP_HI = RS_HI - RW;

  localparam logic [3:0] OP_ADDM = 4'd1;
  localparam logic [3:0] OP_JMP  = 4'd2;
  localparam logic [3:0] OP_JNEG = 4'd3;

  typedef enum logic [2:0] {SRC_PC, SRC_Z, SRC_MDR, SRC_RS, SRC_RD, SRC_OFF} src_t;

  logic [2:0]   step;
  logic [W-1:0] pc, ir, mar, mdr, y, z;
  logic [W-1:0] gpr [NREG];
  logic         neg, busy;

  src_t         src;
  logic         mar_in, pc_in, y_in, z_in, ir_in, r_in, n_in, sel4, req, wmfc, fin;
  logic [W-1:0] bus, alu_a, sum;

  wire [3:0]    op    = ir[W-1 -: 4];
  wire [RW-1:0] f_rd  = ir[RD_HI -: RW];
  wire [RW-1:0] f_rs  = ir[RS_HI -: RW];
  wire [W-1:0]  off_x = {{(W-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};
  wire          unused_gap = ^ir[GAP_HI:OFFW];

  always_comb begin
    src = SRC_PC;
    {mar_in, pc_in, y_in, z_in, ir_in, r_in, n_in, sel4, req, wmfc, fin} = '0;
    case (step)
      3'd1: begin src = SRC_PC;  mar_in = 1'b1; sel4 = 1'b1; z_in = 1'b1; req = 1'b1; end
      3'd2: begin src = SRC_Z;   pc_in = 1'b1; y_in = 1'b1; wmfc = 1'b1; end
      3'd3: begin src = SRC_MDR; ir_in = 1'b1; end
      default: begin
        case (op)
          OP_ADDM: begin
            case (step)
              3'd4: begin src = SRC_RS;  mar_in = 1'b1; req = 1'b1; end
              3'd5: begin src = SRC_RD;  y_in = 1'b1; wmfc = 1'b1; end
              3'd6: begin src = SRC_MDR; z_in = 1'b1; n_in = 1'b1; end
              default: begin src = SRC_Z; r_in = 1'b1; fin = 1'b1; end
            endcase
          end
          OP_JMP, OP_JNEG: begin
            if (step == 3'd4) begin
              if (op == OP_JNEG && !neg) fin = 1'b1;
              else begin src = SRC_OFF; z_in = 1'b1; end
            end else begin
              src = SRC_Z; pc_in = 1'b1; fin = 1'b1;
            end
          end
          default: fin = 1'b1;
        endcase
      end
    endcase
  end

  always_comb begin
    case (src)
      SRC_PC:  bus = pc;
      SRC_Z:   bus = z;
      SRC_MDR: bus = mdr;
      SRC_RS:  bus = gpr[f_rs];
      SRC_RD:  bus = gpr[f_rd];
      default: bus = off_x;
    endcase
  end

  assign alu_a = sel4 ? W'(4) : y;
  assign sum   = alu_a + bus;
  wire   got   = busy && mem_done;
  wire   run   = !wmfc || got;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= 3'd1;
      pc   <= '0;
      ir   <= '0;
      mar  <= '0;
      mdr  <= '0;
      y    <= '0;
      z    <= '0;
      neg  <= 1'b0;
      busy <= 1'b0;
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else begin
      if (fin)      step <= 3'd1;
      else if (run) step <= step + 3'd1;
      if (mar_in) mar <= bus;
      if (pc_in)  pc  <= bus;
      if (y_in)   y   <= bus;
      if (z_in)   z   <= sum;
      if (ir_in)  ir  <= bus;
      if (n_in)   neg <= sum[W-1];
      if (r_in)   gpr[f_rd] <= bus;
      if (got)    mdr <= mem_rdata;
      if (req)      busy <= 1'b1;
      else if (got) busy <= 1'b0;
    end
  end

  assign mem_addr = mar;
  assign mem_rd   = busy;
endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   step,
  input logic [W-1:0] pc,
  input logic         mem_rd,
  input logic         mem_done,
  input logic [W-1:0] mem_addr
);
  assert_step_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step != 3'd0));

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd1) |=> (mem_addr == $past(pc)));

  assert_pc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(step == 3'd2 || step == 3'd5) |=> $stable(pc));

  assert_hold_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_done) |=> $stable(step));

  assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_done) |=> (mem_rd && $stable(mem_addr)));

  assert_read_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (step == 3'd2 || step == 3'd5));

  assert_add_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd7) |=> (step == 3'd1));
endmodule

bind sbus_core sbus_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .pc(pc),
  .mem_rd(mem_rd), .mem_done(mem_done), .mem_addr(mem_addr)
);

// File: tb/sbus_core_bench.sv
`timescale 1ns/1ps
module sbus_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata = '0;
  logic        mem_done = 1'b0;

  always #2 clk = ~clk;

  sbus_core u_sbus_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  logic [31:0] mem [256];
  logic [31:0] log_addr [64];
  int          log_cyc [64];
  logic [31:0] exp_addr [64];
  int log_n = 0, cyc = 0, lat_cfg = 0, wcnt = 0;
  logic prev_rd = 1'b0;
  int total = 0, bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_done = 1'b0; wcnt = 0; prev_rd = 1'b0;
    end else begin
      if (mem_rd && !prev_rd && log_n < 64) begin
        log_addr[log_n] = mem_addr; log_cyc[log_n] = cyc; log_n++;
      end
      prev_rd = mem_rd;
      if (mem_rd && !mem_done) begin
        if (wcnt >= lat_cfg) begin
          mem_done = 1'b1; mem_rdata = mem[mem_addr[9:2]]; wcnt = 0;
        end else wcnt++;
      end else mem_done = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int rd, input int rs,
                                      input logic [15:0] off);
    logic [3:0] o = op[3:0], d = rd[3:0], s = rs[3:0];
    return {o, d, s, 4'h0, off};
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic fill_nop();
    for (int i = 0; i < 256; i++) begin
      logic [31:0] w = rnd();
      w[31:28] = ((i % 13) == 0) ? 4'd0 : 4'(3 + (i % 13));
      mem[i] = w;
    end
  endtask

  task automatic ref_run(input int n);
    logic [31:0] r [16];
    logic [31:0] p, ins, v, offx;
    bit nf;
    int k;
    p = '0; nf = 1'b0; k = 0;
    for (int i = 0; i < 16; i++) r[i] = '0;
    while (k < n) begin
      exp_addr[k] = p; k++;
      ins  = mem[p[9:2]];
      p    = p + 32'd4;
      offx = {{16{ins[15]}}, ins[15:0]};
      case (ins[31:28])
        4'd1: begin
          if (k < n) exp_addr[k] = r[ins[23:20]];
          k++;
          v = r[ins[27:24]] + mem[r[ins[23:20]][9:2]];
          r[ins[27:24]] = v;
          nf = v[31];
        end
        4'd2: p = p + offx;
        4'd3: if (nf) p = p + offx;
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    log_n = 0;
    for (int i = 0; i < 64; i++) log_addr[i] = 32'hDEAD_BEEF;
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rd == 1'b0, "R1", "mem_rd in first cycle", {31'd0, mem_rd}, 32'd0);
  endtask

  task automatic run_prog(input int lat, input int n, input string tag);
    int guard = 0;
    lat_cfg = lat;
    do_reset();
    while (log_n < n && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    ref_run(n);
    chk(log_addr[0] == 32'd0, "R1", "first read address", log_addr[0], 32'd0);
    for (int i = 0; i < n; i++)
      chk(log_addr[i] == exp_addr[i], tag, $sformatf("read %0d addr", i),
          log_addr[i], exp_addr[i]);
  endtask

  initial begin
    for (int lat = 0; lat <= 4; lat++) begin
      fill_nop();
      run_prog(lat, 12, "R2 R9");
      for (int i = 1; i < 12; i++)
        chk(log_cyc[i] - log_cyc[i-1] == lat + 4, "R3",
            $sformatf("fetch gap lat=%0d", lat),
            32'(log_cyc[i] - log_cyc[i-1]), 32'(lat + 4));
    end

    for (int lat = 0; lat <= 2; lat += 2) begin
      fill_nop();
      mem[0] = enc(1, 0, 0, 16'h0);
      mem[1] = enc(1, 2, 0, 16'h0);
      mem[2] = enc(1, 0, 0, 16'h0);
      mem[3] = enc(1, 2, 0, 16'h0);
      run_prog(lat, 8, "R4 R5");
      chk(log_addr[3] == 32'h1000_0000, "R5", "self add first", log_addr[3], 32'h1000_0000);
      chk(log_addr[7] == 32'h2000_0000, "R5", "self add second", log_addr[7], 32'h2000_0000);
    end

    for (int lat = 0; lat <= 3; lat += 3) begin
      fill_nop();
      mem[0] = enc(2, 0, 0, 16'd8);
      mem[3] = enc(2, 0, 0, 16'hFFF4);
      mem[2] = enc(2, 0, 0, 16'h8000);
      run_prog(lat, 10, "R6");
      chk(log_addr[1] == 32'd12, "R6", "forward target", log_addr[1], 32'd12);
      chk(log_addr[2] == 32'd4, "R6", "backward target", log_addr[2], 32'd4);
      chk(log_addr[4] == 32'hFFFF_800C, "R6", "wrapping target", log_addr[4], 32'hFFFF_800C);
    end

    for (int lat = 0; lat <= 1; lat++) begin
      fill_nop();
      mem[0]  = enc(1, 1, 2, 16'h0100);
      mem[1]  = enc(3, 0, 0, 16'd100);
      mem[2]  = enc(1, 1, 1, 16'h0);
      mem[3]  = enc(3, 0, 0, 16'd32);
      mem[12] = enc(3, 0, 0, 16'hFFF8);
      mem[64] = 32'h8000_0000;
      run_prog(lat, 10, "R7 R8");
      chk(log_addr[3] == 32'd8, "R7", "not taken with flag 0", log_addr[3], 32'd8);
      chk(log_addr[4] == 32'h1120_0100, "R4", "operand address", log_addr[4], 32'h1120_0100);
      chk(log_addr[6] == 32'd48, "R7", "taken with flag 1", log_addr[6], 32'd48);
      chk(log_addr[7] == 32'd44, "R8", "flag kept across fetches", log_addr[7], 32'd44);
    end

    for (int s = 0; s < 8; s++) begin
      for (int lat = 0; lat <= 2; lat++) begin
        seed = 32'h9E37_79B9 + 32'(s * 7919);
        for (int i = 0; i < 256; i++) begin
          logic [31:0] w = rnd();
          logic [31:0] x = rnd();
          case (x[1:0])
            2'd0: w[31:28] = 4'd1;
            2'd1: begin w[31:28] = 4'd2; w[15:0] = 16'(((int'(x[8:4]) - 16) * 4)); end
            2'd2: begin w[31:28] = 4'd3; w[15:0] = 16'(((int'(x[8:4]) - 16) * 4)); end
            default: w[31:28] = x[2] ? 4'd0 : 4'(4 + (x[7:4] % 12));
          endcase
          mem[i] = w;
        end
        run_prog(lat, 40, "R4 R6 R7 R8");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule